// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block sits behind a clock-and-data recovery stage that hands it one recovered line bit per bit-clock enable. The line carries 12-bit frames: a high start bit, ten payload bits, then a low stop bit. The low-to-high edge from a stop bit into the next start bit is the only feature that marks where a frame begins. The detector watches all twelve possible alignments at once. For each one it counts how many frames in a row have shown such an edge at that alignment. It declares lock when one alignment has been confirmed often enough and no other alignment keeps producing look-alike edges.

Once locked, the detector emits the ten payload bits of each frame together with a single-cycle word strobe. The strobe fires when the start bit of the next frame confirms the frame boundary. Lock survives a few lost boundaries and is dropped after a run of misses; the detector then returns to hunting. A receive enable masks the parallel outputs without disturbing lock. An active-low power control clears the detector back to the hunting state. Disabled outputs are driven to zero and flagged by an output-enable signal, in place of real high-impedance pads.

Top module: `frame_lock_detector`

## Requirements
- R1: After reset, lock_no_o is 1, out_en_o is 0, word_vld_o is 0 and word_o is zero.
- R2: A boundary is a 0 bit followed by a 1 bit on consecutive enabled bits. Lock (lock_no_o falling to 0) is taken on the enabled bit that completes the fourth consecutive boundary at the same position modulo 12. Three boundaries are not enough.
- R3: While locked, word_vld_o pulses for one cycle after each enabled bit that shows the boundary at the locked position. word_o then holds the ten bits received between the previous start bit and the stop bit, with the first bit received in word_o[0]. No other strobe occurs.
- R4: While locked, up to three consecutive frames without the boundary at the locked position keep lock. A boundary that is seen clears the miss count.
- R5: The fourth consecutive missing boundary drops lock (lock_no_o goes to 1, out_en_o to 0), and the detector returns to hunting.
- R6: While hunting, lock is withheld if any other position has shown a 0-to-1 edge in each of its last two frames. Lock is taken at the first qualified boundary after that pattern has stopped.
- R7: While locked, extra 0-to-1 edges that recur at other positions neither drop lock nor corrupt the delivered words.
- R8: With rx_en_i low, out_en_o and word_vld_o are 0, and lock_no_o still shows the lock state.
- R9: With pwr_up_i low, the detector is cleared to hunting: lock_no_o is 1 and out_en_o is 0. After power returns, a fresh run of four boundaries is needed to lock.
- R10: Cycles with bit_en_i low leave all detector state unchanged.
- R11: word_o reads as zero whenever out_en_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Low powers the detector down and clears it to hunting |
| rx_en_i | input | 1 | Receive enable; low masks the word outputs |
| bit_en_i | input | 1 | Qualifies bit_i for one bit time |
| bit_i | input | 1 | Recovered line bit |
| lock_no_o | output | 1 | Lock flag, active low |
| word_o | output | 10 | Aligned payload word, first received bit in bit 0 |
| word_vld_o | output | 1 | One-cycle strobe for word_o |
| out_en_o | output | 1 | High while word_o and word_vld_o are driven |

## Verification
Two functions can act on the same enabled bit. One is the lock decision, where a fourth confirming boundary competes with a look-alike edge still counted at another position. The other is the miss accounting while locked, where a confirming boundary lands right after a run of misses. The bench provokes the first by switching from a two-edge pattern to a sync pattern. It judges that lock is withheld for exactly one frame and that the first word delivered is the sync payload. It provokes the second by placing a good frame after three blank frames and then three more blank frames. Lock must survive until a fourth consecutive blank frame. Every delivered word is compared in order against a queue the driver fills.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } lock_st_e;
endpackage

// File: rtl/fld_bit_window.sv
module fld_bit_window #(
  parameter int DATA_W  = 10,
  parameter int FRAME_W = DATA_W + 2,
  parameter int PH_W    = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic              bit_i,
  output logic [PH_W-1:0]   ph_o,
  output logic              edge_o,
  output logic [DATA_W-1:0] cand_o
);
  localparam int SH_W = FRAME_W - 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAME_W - 1);

  logic [SH_W-1:0] sh_q;
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      ph_q <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
      ph_q <= '0;
    end else if (adv_i) begin
      sh_q <= {sh_q[SH_W-2:0], bit_i};
      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  // boundary: previous bit low, incoming bit high
  assign edge_o = adv_i & ~sh_q[0] & bit_i;
  assign ph_o   = ph_q;

  // with the start bit arriving, sh_q[DATA_W] holds the first payload bit
  for (genvar i = 0; i < DATA_W; i++) begin : g_cand
    assign cand_o[i] = sh_q[DATA_W-i];
  end
endmodule

// File: rtl/fld_pos_track.sv
module fld_pos_track #(
  parameter int FRAME_W = 12,
  parameter int PH_W    = $clog2(FRAME_W),
  parameter int HIT_N   = 4,
  parameter int REP_N   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic            edge_i,
  output logic            qual_o,
  output logic            block_o
);
  localparam int CNT_W = $clog2(HIT_N);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HIT_N - 1);
  localparam logic [CNT_W-1:0] REP_MIN = CNT_W'(REP_N);

  logic [FRAME_W-1:0] qual_vec;
  logic [FRAME_W-1:0] rep_vec;

  for (genvar p = 0; p < FRAME_W; p++) begin : g_pos
    logic [CNT_W-1:0] cnt_q;
    logic             here;

    assign here = adv_i && (ph_i == PH_W'(p));

    // consecutive-frame edge count at this alignment, saturating
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (here)    cnt_q <= !edge_i ? '0 : (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end

    assign qual_vec[p] = here && edge_i && (cnt_q == CNT_MAX);
    assign rep_vec[p]  = (ph_i != PH_W'(p)) && (cnt_q >= REP_MIN);
  end

  assign qual_o  = |qual_vec;
  assign block_o = |rep_vec;
endmodule

// File: rtl/fld_lock_ctrl.sv
module fld_lock_ctrl
  import fld_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PH_W   = 4,
  parameter int MISS_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [PH_W-1:0]   ph_i,
  input  logic              edge_i,
  input  logic              qual_i,
  input  logic              block_i,
  input  logic [DATA_W-1:0] cand_i,
  output logic              locked_o,
  output logic [DATA_W-1:0] word_o,
  output logic              stb_o
);
  localparam int MISS_W = $clog2(MISS_N);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_N - 1);

  lock_st_e          st_q;
  logic [PH_W-1:0]   pos_q;
  logic [MISS_W-1:0] miss_q;
  logic [DATA_W-1:0] word_q;
  logic              stb_q;
  logic              visit;

  assign visit = adv_i && (ph_i == pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      miss_q <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else if (clr_i) begin
      st_q   <= ST_HUNT;
      pos_q  <= '0;
      miss_q <= '0;
      word_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (st_q)
        ST_HUNT: begin
          if (qual_i && !block_i) begin
            st_q   <= ST_LOCK;
            pos_q  <= ph_i;
            miss_q <= '0;
            word_q <= cand_i;
            stb_q  <= 1'b1;
          end
        end
        ST_LOCK: begin
          if (visit) begin
            if (edge_i) begin
              miss_q <= '0;
              word_q <= cand_i;
              stb_q  <= 1'b1;
            end else if (miss_q == MISS_LAST) begin
              st_q   <= ST_HUNT;
              miss_q <= '0;
            end else begin
              miss_q <= miss_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  assign locked_o = (st_q == ST_LOCK);
  assign word_o   = word_q;
  assign stb_o    = stb_q;

  // R6
  rmt_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HUNT && block_i) |=> (st_q == ST_HUNT));

  // R4
  hold_after_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOCK && visit && edge_i && !clr_i) |=> (st_q == ST_LOCK && stb_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> ($stable(st_q) && $stable(word_q)));

  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
endmodule

// File: rtl/frame_lock_detector.sv
module frame_lock_detector #(
  parameter int DATA_W = 10,
  parameter int HIT_N  = 4,
  parameter int MISS_N = 4,
  parameter int REP_N  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_up_i,
  input  logic              rx_en_i,
  input  logic              bit_en_i,
  input  logic              bit_i,
  output logic              lock_no_o,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              out_en_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int PH_W    = $clog2(FRAME_W);

  logic              adv, clr;
  logic [PH_W-1:0]   ph;
  logic              edge_hit, qual, block;
  logic [DATA_W-1:0] cand, word_int;
  logic              locked, stb;

  assign clr = ~pwr_up_i;
  assign adv = bit_en_i & pwr_up_i;

  fld_bit_window #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W),
    .PH_W   (PH_W)
  ) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .adv_i (adv),
    .bit_i (bit_i),
    .ph_o  (ph),
    .edge_o(edge_hit),
    .cand_o(cand)
  );

  fld_pos_track #(
    .FRAME_W(FRAME_W),
    .PH_W   (PH_W),
    .HIT_N  (HIT_N),
    .REP_N  (REP_N)
  ) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .ph_i   (ph),
    .edge_i (edge_hit),
    .qual_o (qual),
    .block_o(block)
  );

  fld_lock_ctrl #(
    .DATA_W(DATA_W),
    .PH_W  (PH_W),
    .MISS_N(MISS_N)
  ) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .adv_i   (adv),
    .ph_i    (ph),
    .edge_i  (edge_hit),
    .qual_i  (qual),
    .block_i (block),
    .cand_i  (cand),
    .locked_o(locked),
    .word_o  (word_int),
    .stb_o   (stb)
  );

  assign lock_no_o  = ~(locked & pwr_up_i);
  assign out_en_o   = locked & pwr_up_i & rx_en_i;
  assign word_vld_o = stb & out_en_o;
  assign word_o     = out_en_o ? word_int : '0;

  // R9
  pwr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_up_i ##1 pwr_up_i) |-> lock_no_o);

  // R8
  vld_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |-> (!lock_no_o && rx_en_i));

  // R11
  word_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_i || lock_no_o) |-> (word_o == '0));
endmodule

// File: tb/tb_frame_lock_detector.sv
module tb_frame_lock_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_up = 1'b1;
  logic       rx_en = 1'b1;
  logic       bit_en = 1'b0;
  logic       bit_v = 1'b0;
  logic       lock_n;
  logic [9:0] word;
  logic       word_vld;
  logic       out_en;

  int         n_chk = 0;
  int         n_err = 0;
  logic [9:0] exp_q[$];
  logic [9:0] prev_data = '0;
  logic [9:0] exp_w;
  bit         done = 1'b0;

  localparam logic [9:0] SYNC_D = 10'h01F;  // start + five ones, then six zeros
  localparam logic [9:0] RMT_D  = 10'h002;  // second edge at payload bit 1

  always #2 clk = ~clk;

  frame_lock_detector dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pwr_up_i  (pwr_up),
    .rx_en_i   (rx_en),
    .bit_en_i  (bit_en),
    .bit_i     (bit_v),
    .lock_no_o (lock_n),
    .word_o    (word),
    .word_vld_o(word_vld),
    .out_en_o  (out_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: every delivered word must match the head of the queue (R3)
  always @(negedge clk) begin
    if (rst_n && word_vld && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected strobe", {22'd0, word}, 32'hFFFF_FFFF);
      end else begin
        exp_w = exp_q.pop_front();
        chk(word == exp_w, "R3 word", {22'd0, word}, {22'd0, exp_w});
      end
    end
  end

  task automatic drive_bit(input logic b, input int gap);
    repeat (gap) @(posedge clk);
    #1;
    bit_en = 1'b1;
    bit_v  = b;
    @(posedge clk);
    #1;
    bit_en = 1'b0;
  endtask

  task automatic send_raw(input logic [11:0] bits, input int gap);
    for (int i = 0; i < 12; i++) drive_bit(bits[i], gap);
  endtask

  // frame on the line: start 1, payload bit 0 first, stop 0
  task automatic send_frame(input logic [9:0] d, input bit expect_prev, input int gap);
    if (expect_prev) exp_q.push_back(prev_data);
    send_raw({1'b0, d, 1'b1}, gap);
    prev_data = d;
  endtask

  task automatic send_blank();
    send_raw(12'h000, 0);
    prev_data = '0;
  endtask

  task automatic check_lock(input bit exp_locked, input string req);
    @(negedge clk);
    chk(lock_n == !exp_locked, req, {31'd0, lock_n}, {31'd0, !exp_locked});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(lock_n == 1'b1, "R1 lock", {31'd0, lock_n}, 1);
    chk(out_en == 1'b0, "R1 out_en", {31'd0, out_en}, 0);
    chk(word_vld == 1'b0, "R1 vld", {31'd0, word_vld}, 0);
    chk(word == '0, "R1 word", {22'd0, word}, 0);

    // R2: three boundaries do not lock, the fourth does
    repeat (3) send_frame(SYNC_D, 1'b0, 0);
    check_lock(1'b0, "R2 three frames");
    send_frame(SYNC_D, 1'b1, 0);
    check_lock(1'b1, "R2 fourth frame");

    // R3: payload ordering for varied words
    send_frame(10'h2A5, 1'b1, 0);
    send_frame(10'h155, 1'b1, 0);
    send_frame(10'h3FF, 1'b1, 0);
    send_frame(10'h000, 1'b1, 0);
    send_frame(10'h1C3, 1'b1, 0);

    // R10: idle cycles between enabled bits
    send_frame(10'h0F0, 1'b1, 3);
    send_frame(10'h30C, 1'b1, 2);
    check_lock(1'b1, "R10 gaps");

    // R8 and R11: receive enable low masks outputs, lock stays
    @(posedge clk); #1 rx_en = 1'b0;
    send_frame(10'h111, 1'b0, 0);
    @(negedge clk);
    chk(out_en == 1'b0, "R8 out_en", {31'd0, out_en}, 0);
    chk(word == '0, "R11 word", {22'd0, word}, 0);
    chk(lock_n == 1'b0, "R8 lock kept", {31'd0, lock_n}, 0);
    @(posedge clk); #1 rx_en = 1'b1;
    send_frame(10'h222, 1'b1, 0);

    // R7: recurring extra edge while locked
    repeat (5) send_frame(RMT_D, 1'b1, 0);
    check_lock(1'b1, "R7 rmt while locked");

    // R4: three misses hold, a hit clears the count
    repeat (3) send_blank();
    check_lock(1'b1, "R4 three misses");
    send_frame(10'h0AA, 1'b1, 0);
    repeat (3) send_blank();
    check_lock(1'b1, "R4 count cleared");

    // R5: fourth consecutive miss drops lock
    send_blank();
    check_lock(1'b0, "R5 fourth miss");
    chk(out_en == 1'b0, "R5 out_en", {31'd0, out_en}, 0);

    // R6: two recurring edges block lock until the pattern stops
    repeat (6) send_frame(RMT_D, 1'b0, 0);
    check_lock(1'b0, "R6 blocked");
    send_frame(SYNC_D, 1'b0, 0);
    check_lock(1'b0, "R6 competitor still counted");
    send_frame(SYNC_D, 1'b1, 0);
    check_lock(1'b1, "R6 lock after clear");

    // R9: power-down clears, reacquire needs four frames
    @(posedge clk); #1 pwr_up = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(lock_n == 1'b1, "R9 lock", {31'd0, lock_n}, 1);
    chk(out_en == 1'b0, "R9 out_en", {31'd0, out_en}, 0);
    chk(word == '0, "R9 word", {22'd0, word}, 0);
    @(posedge clk); #1 pwr_up = 1'b1;
    check_lock(1'b0, "R9 after power return");
    repeat (3) send_frame(SYNC_D, 1'b0, 0);
    check_lock(1'b0, "R9 three frames");
    send_frame(SYNC_D, 1'b1, 0);
    check_lock(1'b1, "R9 relock");
    send_frame(10'h3A1, 1'b1, 0);
    send_frame(10'h000, 1'b1, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3 missing strobes", exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule